// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt events from a group of peripheral sources and picks one of them to offer the processor. Each source has three pieces of state. The first is a request flag that an event sets and only software clears. The second is an enable bit. The third is a two-bit urgency level. The levels are written through small byte-wide level registers. A smaller level number means a more urgent request, and level 3 takes a source out of arbitration.

On every cycle a combinational search finds the most urgent pending, enabled request. When several requests share the best level, the lowest source number wins. The result is registered as the candidate level and source. An acceptance stage then compares the candidate with the processor's current interrupt level and with the global interrupt enable. If the candidate is strictly more urgent than the current level and interrupts are enabled, the stage does three things: it pulses an acknowledge for one cycle, it presents the source index as the vector number, and it loads the candidate's level as the new current level. A return input reloads the current level from a value that the processor supplies. A separate wake output reports any pending, enabled flag so that the device can leave its low-power state.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, every level register holds 8'hFF, so every source is at level 3. All enables and flags are 0, `cur_level` is 3, and `win_valid`, `ack` and `wake` are 0.
- R2: A write with `lvl_we` high and `lvl_idx` = k below NSRC/4 loads byte k. Source 4k+j then takes its level from bits [2j+1:2j] of that byte. A write to an index at or above NSRC/4 changes nothing.
- R3: An `evt` bit sets the matching flag on the next clock. The flag stays 1 until a `flag_clr` bit for that source is seen. When an event and a clear reach the same source in the same cycle, the flag ends up set.
- R4: Only sources that have flag=1, enable=1 and a level other than 3 take part in arbitration. The winner appears on `win_valid`, `win_level` and `win_src` one clock after the flag becomes visible.
- R5: The lowest level number wins. Among requests at the same level, the lowest source index wins.
- R6: On a clock edge where `win_valid` is 1, `ie` is 1, `win_level` is less than `cur_level` and `ret` is 0, the following happens after that edge: `ack` is 1 for one cycle, `ack_src` equals `win_src`, and `cur_level` equals `win_level`. `ack` is 0 whenever these conditions are not met.
- R7: Acceptance does not clear any flag. A request whose level equals `cur_level` is not accepted again.
- R8: `ret` loads `cur_level` from `ret_level` on the next clock. It blocks acceptance in the same cycle.
- R9: `wake` is the OR over all sources of flag AND enable. It does not depend on level or `ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt | input | NSRC | Per-source event pulses that set request flags |
| flag_clr | input | NSRC | Per-source software clear of the request flag |
| en_wr | input | 1 | Load the enable bits from en_wdata |
| en_wdata | input | NSRC | New per-source enable bits |
| lvl_we | input | 1 | Write strobe for a level register |
| lvl_idx | input | IW | Level register index |
| lvl_wdata | input | 8 | Four packed 2-bit levels |
| ie | input | 1 | Global interrupt enable |
| ret | input | 1 | Return from interrupt: reload current level |
| ret_level | input | 2 | Level restored on return |
| win_valid | output | 1 | A candidate request exists |
| win_level | output | 2 | Candidate level |
| win_src | output | SW | Candidate source index |
| cur_level | output | 2 | Current interrupt level |
| ack | output | 1 | One-cycle acceptance pulse |
| ack_src | output | SW | Vector index of the accepted source |
| wake | output | 1 | Pending enabled request exists |

## Verification
The hardest case to reach is the cycle in which a return and a valid acceptance coincide. To get there, the bench first raises the current level to 3 while `ie` is low, so that a level-1 candidate sits waiting. It then raises `ie` and `ret` (with level 0) together, and checks that no acknowledge follows and that the restored level stands. Ties are built by leaving an earlier flag set while later equal-level sources fire. The earlier flag is then cleared so that the next source in index order must take over.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int NSRC = 24,
  localparam int NREG = (NSRC + 3) / 4,
  localparam int IW = $clog2(NREG + 1),
  localparam int SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] flag_clr,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic            lvl_we,
  input  logic [IW-1:0]   lvl_idx,
  input  logic [7:0]      lvl_wdata,
  input  logic            ie,
  input  logic            ret,
  input  logic [1:0]      ret_level,
  output logic            win_valid,
  output logic [1:0]      win_level,
  output logic [SW-1:0]   win_src,
  output logic [1:0]      cur_level,
  output logic            ack,
  output logic [SW-1:0]   ack_src,
  output logic            wake
);

  logic [7:0]      lvl_reg [NREG];
  logic [1:0]      src_lvl [NSRC];
  logic [NSRC-1:0] flag, en, act;
  logic            best_v;
  logic [1:0]      best_l;
  logic [SW-1:0]   best_s;
  logic            take;

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    assign src_lvl[i] = lvl_reg[i / 4][2 * (i % 4) +: 2];
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) lvl_reg[k] <= 8'hFF;
      else if (lvl_we && lvl_idx == IW'(k)) lvl_reg[k] <= lvl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= '0;
      en   <= '0;
    end else begin
      flag <= (flag & ~flag_clr) | evt;
      if (en_wr) en <= en_wdata;
    end
  end

  assign act  = flag & en;
  assign wake = |act;

  always_comb begin
    best_v = 1'b0;
    best_l = 2'd3;
    best_s = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i] && src_lvl[i] != 2'd3 && src_lvl[i] <= best_l) begin
        best_v = 1'b1;
        best_l = src_lvl[i];
        best_s = SW'(i);
      end
    end
  end

  assign take = win_valid && ie && !ret && (win_level < cur_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_level <= 2'd3;
      win_src   <= '0;
      cur_level <= 2'd3;
      ack       <= 1'b0;
      ack_src   <= '0;
    end else begin
      win_valid <= best_v;
      win_level <= best_l;
      win_src   <= best_s;
      ack       <= take;
      if (take) ack_src <= win_src;
      if (ret) cur_level <= ret_level;
      else if (take) cur_level <= win_level;
    end
  end

  a_r6_ack_needs_urgent: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($past(win_valid) && $past(ie) && ($past(win_level) < $past(cur_level))));
  a_r6_level_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (cur_level == $past(win_level) && ack_src == $past(win_src)));
  a_r8_ret_restores: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ret) |-> (cur_level == $past(ret_level) && !ack));
  a_r4_no_level3_winner: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_level != 2'd3);
  a_r9_wake_before_win: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $past(wake));
  a_r3_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag) & ~$past(flag_clr) & ~flag) == '0));

endmodule

// File: tb/irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module irq_level_ctrl_bench;
  localparam int NSRC = 24;
  localparam int IW = 3;
  localparam int SW = 5;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] evt = '0, flag_clr = '0, en_wdata = '0;
  logic en_wr = 0, lvl_we = 0, ie = 0, ret = 0;
  logic [IW-1:0] lvl_idx = '0;
  logic [7:0] lvl_wdata = '0;
  logic [1:0] ret_level = '0;
  logic win_valid, ack, wake;
  logic [1:0] win_level, cur_level;
  logic [SW-1:0] win_src, ack_src;

  int checks = 0, bad = 0, mchecks = 0, mbad = 0;
  int exp_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_level_ctrl #(.NSRC(NSRC)) u_irq_level_ctrl (
    .clk, .rst_n, .evt, .flag_clr, .en_wr, .en_wdata, .lvl_we, .lvl_idx,
    .lvl_wdata, .ie, .ret, .ret_level, .win_valid, .win_level, .win_src,
    .cur_level, .ack, .ack_src, .wake);

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_evt(input logic [NSRC-1:0] m);
    evt = m; tick; evt = '0;
  endtask

  task automatic clr(input logic [NSRC-1:0] m);
    flag_clr = m; tick; flag_clr = '0;
  endtask

  task automatic wr_lvl(input int idx, input logic [7:0] d);
    lvl_we = 1; lvl_idx = IW'(idx); lvl_wdata = d; tick; lvl_we = 0;
  endtask

  task automatic chk_win(input string req, input int lvl, input int src);
    chk(win_valid == 1, req, win_valid, 1);
    chk(win_level == lvl, req, win_level, lvl);
    chk(win_src == src, req, win_src, src);
  endtask

  always @(negedge clk) begin
    if (rst_n && ack) begin
      mchecks++;
      if (exp_q.size() == 0) begin
        mbad++;
        $display("FAIL R6 unexpected ack act=%0d exp=none", ack_src);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (ack_src != e) begin
          mbad++;
          $display("FAIL R6 ack_src act=%0d exp=%0d", ack_src, e);
        end
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks + mchecks, bad + mbad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog all act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick;
    rst_n = 1;
    // R1 reset state
    chk(cur_level == 3, "R1 cur_level", cur_level, 3);
    chk(win_valid == 0 && ack == 0 && wake == 0, "R1 outputs idle", {win_valid, ack, wake}, 0);

    en_wr = 1; en_wdata = '1; tick; en_wr = 0;
    pulse_evt(24'd1 << 5);
    chk(wake == 1, "R9 wake on level-3 source", wake, 1);
    tick;
    chk(win_valid == 0, "R1 default level 3 excluded (R4)", win_valid, 0);
    clr(24'd1 << 5);
    chk(wake == 0, "R3 clear drops flag", wake, 0);

    wr_lvl(1, 8'b11_10_01_11);        // src4=3 src5=1 src6=2 src7=3
    wr_lvl(6, 8'h00);                 // R2 out of range, ignored
    pulse_evt(24'd1 << 0); tick;
    chk(win_valid == 0, "R2 out-of-range write ignored", win_valid, 0);
    clr(24'd1 << 0);

    pulse_evt(24'd1 << 6); tick;
    chk_win("R4 single level-2 request", 2, 6);
    pulse_evt(24'd1 << 5); tick;
    chk_win("R5 more urgent level wins", 1, 5);
    wr_lvl(2, 8'h55);                 // src8..11 level 1
    pulse_evt((24'd1 << 9) | (24'd1 << 10)); tick;
    chk_win("R5 tie goes to lowest index", 1, 5);
    clr(24'd1 << 5); tick;
    chk_win("R5 tie next index", 1, 9);

    ie = 1; exp_q.push_back(9); tick;
    chk(ack == 1, "R6 ack pulse", ack, 1);
    chk(cur_level == 1, "R6 level loaded", cur_level, 1);
    repeat (3) tick;
    chk(cur_level == 1 && ack == 0, "R7 no re-accept at equal level", cur_level, 1);
    chk(wake == 1, "R7 flag kept after accept", wake, 1);
    chk_win("R7 request still pending", 1, 9);

    wr_lvl(0, 8'hFC);                 // src0 level 0
    exp_q.push_back(0);
    pulse_evt(24'd1 << 0); tick; tick;
    chk(cur_level == 0, "R6 nested accept level 0", cur_level, 0);

    exp_q.push_back(0);
    ret = 1; ret_level = 2'd1; tick; ret = 0;
    chk(cur_level == 1, "R8 return restores level", cur_level, 1);
    tick;
    chk(cur_level == 0, "R6 re-accept after return", cur_level, 0);

    clr(24'd1 << 0); tick; tick;
    ie = 0; ret = 1; ret_level = 2'd3; tick; ret = 0;
    chk(cur_level == 3, "R8 return to level 3", cur_level, 3);
    ie = 1; ret = 1; ret_level = 2'd0; tick; ret = 0;
    chk(cur_level == 0 && ack == 0, "R8 return beats acceptance", cur_level, 0);
    tick;
    chk(ack == 0, "R8 no late ack", ack, 0);

    ie = 0;
    clr('1);
    chk(wake == 0, "R3 all cleared", wake, 0);
    evt = 24'd1 << 3; flag_clr = 24'd1 << 3; tick; evt = '0; flag_clr = '0;
    chk(wake == 1, "R3 set wins over clear", wake, 1);
    en_wr = 1; en_wdata = ~(24'd1 << 3); tick; en_wr = 0;
    chk(wake == 0, "R9 disabled source no wake", wake, 0);
    tick;
    chk(win_valid == 0, "R4 disabled source excluded", win_valid, 0);

    chk(exp_q.size() == 0, "R6 all expected acks seen", exp_q.size(), 0);
    finish_run();
  end
endmodule